// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps calendar time of day in packed BCD: seconds, minutes, hours, a weekday number, day of month, month and a two-digit year whose values 00 to 99 stand for 1970 through 2069. A prescaler divides the block clock, nominally 32768 Hz, into a one-cycle pulse once per second, and every pulse advances the time through a chain of BCD carries. The chain runs from seconds to minutes to hours, from hours to both weekday and day of month, from day to month, and from month to year.

Software never writes the running counters directly. It fills a bank of shadow fields through a 16-bit register port and then writes the update register with its top bit set. That write copies all seven shadow fields and the leap flag into the counters in the same cycle and restarts the prescaler, so the first second after a commit is a full second. Whether February has 29 days is not computed from the year: it follows a flag that software stores in the year register. Register reads return the live counter values.

Register map (word addresses on `reg_addr`): 0 control, 1 seconds, 2 minutes, 3 hours, 4 weekday, 5 day of month, 6 month, 7 year, 8 update. Time fields sit in bits [7:0]; the year register also carries the leap flag in bit 15.

Top module: `rtc_bcd_calendar`

## Requirements
- R1: After reset the live time reads seconds 00, minutes 00, hours 00, weekday 0, day 01, month 01, year 00 with leap flag 0, the control register reads 0x0001, and `sec_tick` is low.
- R2: `sec_tick` is high for exactly one cycle in every PRESCALE cycles; after a commit at clock edge E it is next high in the cycle that follows edge E+PRESCALE-1, and the time advances at edge E+PRESCALE.
- R3: Seconds count 00 to 59 in BCD and roll to 00 with a carry into minutes; minutes count 00 to 59 and roll to 00 with a carry into hours.
- R4: Hours count 00 to 23 in BCD and roll from 23 to 00 with a carry into both weekday and day of month.
- R5: The weekday field (bits [2:0] of address 4) counts 0 to 6 and wraps from 6 to 0.
- R6: Day of month wraps to 01 with a carry into month after 31 days for months 01, 03, 05, 07, 08, 10, 12, after 30 days for months 04, 06, 09, 11, and for month 02 after 29 days when the leap flag (bit 15 of address 7) is 1 and after 28 days when it is 0.
- R7: Month counts 01 to 12 and wraps from 12 to 01 with a carry into year; year counts 00 to 99 and wraps to 00; the leap flag never changes by counting.
- R8: A write to addresses 1 to 7 changes only the shadow fields, masked to the field widths (7 bits for seconds and minutes, 6 for hours and day, 3 for weekday, 5 for month, 8 for year); reads of these addresses return the live values in bits [7:0] (and the live leap flag in bit 15 of address 7) with all other bits 0.
- R9: A write to address 8 with bit 15 set copies all seven shadow fields and the shadow leap flag into the live counters at that clock edge; a write to address 8 with bit 15 clear has no effect; address 8 always reads 0.
- R10: Bit 0 of the control register (address 0) selects 24-hour mode, resets to 1 and reads back as written, its other bits read 0; addresses 9 to 15 read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock, nominally 32768 Hz |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 4 | Register word address for reads and writes |
| reg_wr | input | 1 | Write strobe, one write per cycle in which it is high |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| sec_tick | output | 1 | One-cycle pulse once per second |

## Verification
The hardest situations to reach from the ports are the deep carries, such as a 31 December 23:59:59 in year 99 rolling over, or a February end under each leap setting, since counting there from reset would take years of ticks. The stimulus instead loads a time just before such a boundary through the shadow fields and a commit, runs a small number of ticks with a shortened prescaler, and reads all fields back within one low clock phase so the snapshot is consistent. Random times biased toward the last value of each field are mixed with directed February, 30-day month and year-wrap cases, and the expected values come from a calendar model in the bench.

// File: rtl/rtc_pkg.sv
// Shared definitions for the BCD calendar counter: register addresses,
// field indices, per-field widths and limits, and a BCD increment helper.
// Assumes every field fits in one packed BCD byte.
package rtc_pkg;

    localparam int NFIELD   = 7;
    localparam int DATA_W   = 16;
    localparam int ADDR_W   = 4;
    localparam int LEAP_BIT = 15;
    localparam int TRIG_BIT = 15;

    // Field indices, in carry order
    localparam int F_SEC  = 0;
    localparam int F_MIN  = 1;
    localparam int F_HOUR = 2;
    localparam int F_WDAY = 3;
    localparam int F_MDAY = 4;
    localparam int F_MON  = 5;
    localparam int F_YEAR = 6;

    typedef logic [7:0] bcd8_t;

    typedef enum logic [ADDR_W-1:0] {
        ADR_CTRL   = 4'd0,
        ADR_SEC    = 4'd1,
        ADR_MIN    = 4'd2,
        ADR_HOUR   = 4'd3,
        ADR_WDAY   = 4'd4,
        ADR_MDAY   = 4'd5,
        ADR_MON    = 4'd6,
        ADR_YEAR   = 4'd7,
        ADR_UPDATE = 4'd8
    } rtc_addr_e;

    // Stored width of each field
    function automatic int fld_width(input int idx);
        case (idx)
            F_SEC, F_MIN:   return 7;
            F_HOUR, F_MDAY: return 6;
            F_WDAY:         return 3;
            F_MON:          return 5;
            default:        return 8;
        endcase
    endfunction

    // Bit mask of each field inside its byte
    function automatic bcd8_t fld_mask(input int idx);
        return bcd8_t'((1 << fld_width(idx)) - 1);
    endfunction

    // Value each field restarts from after a wrap
    function automatic bcd8_t fld_min(input int idx);
        return (idx == F_MDAY || idx == F_MON) ? 8'h01 : 8'h00;
    endfunction

    // Last value of each field before it wraps (day of month is dynamic)
    function automatic bcd8_t fld_max(input int idx);
        case (idx)
            F_SEC, F_MIN: return 8'h59;
            F_HOUR:       return 8'h23;
            F_WDAY:       return 8'h06;
            F_MDAY:       return 8'h31;
            F_MON:        return 8'h12;
            default:      return 8'h99;
        endcase
    endfunction

    // Add one to a two-digit packed BCD value
    function automatic bcd8_t bcd_inc(input bcd8_t v);
        if (v[3:0] >= 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return {v[7:4], v[3:0] + 4'd1};
    endfunction

endpackage

// File: rtl/rtc_prescaler.sv
// Divides the block clock by PRESCALE into a one-cycle pulse.
// Assumes PRESCALE >= 2. A restart returns the count to zero, so the
// next pulse comes a full PRESCALE cycles after the restart edge.
module rtc_prescaler #(
    parameter int PRESCALE = 32768
) (
    input  logic clk,
    input  logic rst_n,
    input  logic restart,
    output logic tick
);
    localparam int CW = $clog2(PRESCALE);
    localparam logic [CW-1:0] LAST = CW'(PRESCALE - 1);

    logic [CW-1:0] cnt;

    // Free-running divide counter with synchronous restart
    always_ff @(posedge clk) begin
        if (!rst_n || restart)
            cnt <= '0;
        else if (cnt == LAST)
            cnt <= '0;
        else
            cnt <= cnt + 1'b1;
    end

    assign tick = (cnt == LAST);

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R2
    AST_RESTART_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !tick); // R2

endmodule

// File: rtl/rtc_bcd_field.sv
// One BCD time field: loads a masked value, or on a step advances by one
// BCD count and wraps from max_val back to MINV, flagging the carry.
// Assumes loaded values are valid BCD within the field's range.
module rtc_bcd_field
    import rtc_pkg::*;
#(
    parameter int    W    = 8,
    parameter bcd8_t MINV = 8'h00
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  load,
    input  bcd8_t load_val,
    input  bcd8_t max_val,
    output bcd8_t val,
    output logic  wrap
);
    localparam bcd8_t MASK = bcd8_t'((1 << W) - 1);

    // Field register: load beats step, step counts or wraps
    always_ff @(posedge clk) begin
        if (!rst_n)
            val <= MINV;
        else if (load)
            val <= load_val & MASK;
        else if (step) begin
            if (val == max_val)
                val <= MINV;
            else
                val <= bcd_inc(val) & MASK;
        end
    end

    assign wrap = step && !load && (val == max_val);

    AST_FIELD_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !load && val == max_val) |=> (val == MINV)); // R3
    AST_FIELD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && !load) |=> $stable(val)); // R8

endmodule

// File: rtl/rtc_month_len.sv
// Gives the last day of a month in BCD. February follows the leap flag
// supplied by software; nothing is derived from the year value.
module rtc_month_len
    import rtc_pkg::*;
(
    input  bcd8_t month,
    input  logic  leap,
    output bcd8_t last_day
);
    // Month length lookup
    always_comb begin
        case (month)
            8'h02:                      last_day = leap ? 8'h29 : 8'h28;
            8'h04, 8'h06, 8'h09, 8'h11: last_day = 8'h30;
            default:                    last_day = 8'h31;
        endcase
    end

endmodule

// File: rtl/rtc_time_core.sv
// The live calendar: seven BCD fields chained by carries, plus the leap
// flag. Hours carry into weekday and day of month in the same step.
// Assumes load and step may coincide; load wins in every field.
module rtc_time_core
    import rtc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step,
    input  logic                    load,
    input  logic [NFIELD-1:0][7:0]  load_fields,
    input  logic                    load_leap,
    output logic [NFIELD-1:0][7:0]  live,
    output logic                    leap_live
);
    logic [NFIELD-1:0] en;
    logic [NFIELD-1:0] wrap;
    bcd8_t             mday_last;
    logic              unused_top_wrap;

    assign unused_top_wrap = wrap[F_YEAR];

    // Carry routing between fields
    always_comb begin
        en[F_SEC]  = step;
        en[F_MIN]  = wrap[F_SEC];
        en[F_HOUR] = wrap[F_MIN];
        en[F_WDAY] = wrap[F_HOUR];
        en[F_MDAY] = wrap[F_HOUR];
        en[F_MON]  = wrap[F_MDAY];
        en[F_YEAR] = wrap[F_MON];
    end

    rtc_month_len u_mlen (
        .month    (live[F_MON]),
        .leap     (leap_live),
        .last_day (mday_last)
    );

    for (genvar i = 0; i < NFIELD; i++) begin : g_field
        localparam bcd8_t FMAX = fld_max(i);
        rtc_bcd_field #(
            .W    (fld_width(i)),
            .MINV (fld_min(i))
        ) u_fld (
            .clk      (clk),
            .rst_n    (rst_n),
            .step     (en[i]),
            .load     (load),
            .load_val (load_fields[i]),
            .max_val  ((i == F_MDAY) ? mday_last : FMAX),
            .val      (live[i]),
            .wrap     (wrap[i])
        );
    end

    // Live leap flag changes only on a commit
    always_ff @(posedge clk) begin
        if (!rst_n)
            leap_live <= 1'b0;
        else if (load)
            leap_live <= load_leap;
    end

    AST_DAY_TO_MONTH: assert property (@(posedge clk) disable iff (!rst_n)
        wrap[F_MDAY] |=> (live[F_MDAY] == 8'h01 && live[F_MON] != $past(live[F_MON]))); // R6
    AST_HOUR_TO_WDAY: assert property (@(posedge clk) disable iff (!rst_n)
        (wrap[F_HOUR] && live[F_WDAY] == 8'h06) |=> (live[F_WDAY] == 8'h00)); // R5
    AST_LEAP_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(leap_live)); // R7

endmodule

// File: rtl/rtc_regfile.sv
// Register port: shadow time fields, control register, read mux and the
// commit decode. Reads of time registers return live counter values.
// Assumes one access per cycle; read data is combinational.
module rtc_regfile
    import rtc_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic                    wr,
    input  logic [DATA_W-1:0]       wdata,
    input  logic [NFIELD-1:0][7:0]  live,
    input  logic                    leap_live,
    output logic [DATA_W-1:0]       rdata,
    output logic [NFIELD-1:0][7:0]  shadow,
    output logic                    shadow_leap,
    output logic                    commit
);
    logic mode_24h;
    logic unused_wbits;

    assign unused_wbits = ^wdata[14:8];

    // Shadow fields capture writes to the time addresses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NFIELD; i++)
                shadow[i] <= fld_min(i);
            shadow_leap <= 1'b0;
        end else if (wr) begin
            for (int i = 0; i < NFIELD; i++)
                if (addr == ADDR_W'(i + 1))
                    shadow[i] <= wdata[7:0] & fld_mask(i);
            if (addr == ADR_YEAR)
                shadow_leap <= wdata[LEAP_BIT];
        end
    end

    // Control register, hour mode bit
    always_ff @(posedge clk) begin
        if (!rst_n)
            mode_24h <= 1'b1;
        else if (wr && addr == ADR_CTRL)
            mode_24h <= wdata[0];
    end

    assign commit = wr && (addr == ADR_UPDATE) && wdata[TRIG_BIT];

    // Read data selection
    always_comb begin
        rdata = '0;
        case (addr)
            ADR_CTRL: rdata[0]    = mode_24h;
            ADR_SEC:  rdata[7:0]  = live[F_SEC];
            ADR_MIN:  rdata[7:0]  = live[F_MIN];
            ADR_HOUR: rdata[7:0]  = live[F_HOUR];
            ADR_WDAY: rdata[7:0]  = live[F_WDAY];
            ADR_MDAY: rdata[7:0]  = live[F_MDAY];
            ADR_MON:  rdata[7:0]  = live[F_MON];
            ADR_YEAR: begin
                rdata[7:0]      = live[F_YEAR];
                rdata[LEAP_BIT] = leap_live;
            end
            default:  rdata = '0;
        endcase
    end

    AST_UPD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADR_UPDATE) |-> (rdata == '0)); // R9
    AST_CTRL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && addr == ADR_CTRL) |=> (mode_24h == $past(wdata[0]))); // R10

endmodule

// File: rtl/rtc_bcd_calendar.sv
// Top of the BCD calendar counter: prescaler, live time core and the
// register port. A commit loads the shadow bank and restarts the second.
// Assumes clk runs at the rate PRESCALE is chosen for (32768 Hz default).
module rtc_bcd_calendar
    import rtc_pkg::*;
#(
    parameter int PRESCALE = 32768
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [3:0]        reg_addr,
    input  logic              reg_wr,
    input  logic [15:0]       reg_wdata,
    output logic [15:0]       reg_rdata,
    output logic              sec_tick
);
    logic [NFIELD-1:0][7:0] live;
    logic [NFIELD-1:0][7:0] shadow;
    logic                   leap_live;
    logic                   shadow_leap;
    logic                   commit;

    rtc_prescaler #(.PRESCALE(PRESCALE)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (commit),
        .tick    (sec_tick)
    );

    rtc_time_core u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (sec_tick),
        .load        (commit),
        .load_fields (shadow),
        .load_leap   (shadow_leap),
        .live        (live),
        .leap_live   (leap_live)
    );

    rtc_regfile u_regs (
        .clk         (clk),
        .rst_n       (rst_n),
        .addr        (reg_addr),
        .wr          (reg_wr),
        .wdata       (reg_wdata),
        .live        (live),
        .leap_live   (leap_live),
        .rdata       (reg_rdata),
        .shadow      (shadow),
        .shadow_leap (shadow_leap),
        .commit      (commit)
    );

    AST_COMMIT_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (live == $past(shadow) && leap_live == $past(shadow_leap))); // R9
    AST_NO_STEP_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!sec_tick && !commit) |=> $stable(live)); // R8

endmodule

// File: tb/sim_rtc_bcd_calendar.sv
// Self-checking bench: directed boundary cases plus seeded random times
// near rollovers, compared with a calendar model kept in the bench.
module sim_rtc_bcd_calendar;
    localparam int P = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  reg_addr = 4'd0;
    logic        reg_wr = 1'b0;
    logic [15:0] reg_wdata = 16'd0;
    logic [15:0] reg_rdata;
    logic        sec_tick;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    int m_sec, m_min, m_hr, m_wd, m_md, m_mo, m_yr;
    bit m_leap;

    rtc_bcd_calendar #(.PRESCALE(P)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .sec_tick  (sec_tick)
    );

    always #10 clk = ~clk;

    function automatic logic [7:0] to_bcd(input int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    function automatic int mlen(input int mo, input bit leap);
        if (mo == 2) return leap ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic model_step();
        m_sec++;
        if (m_sec == 60) begin
            m_sec = 0; m_min++;
            if (m_min == 60) begin
                m_min = 0; m_hr++;
                if (m_hr == 24) begin
                    m_hr = 0;
                    m_wd = (m_wd + 1) % 7;
                    m_md++;
                    if (m_md > mlen(m_mo, m_leap)) begin
                        m_md = 1; m_mo++;
                        if (m_mo == 13) begin
                            m_mo = 1;
                            m_yr = (m_yr + 1) % 100;
                        end
                    end
                end
            end
        end
    endtask

    // Write one register; returns 1 ns after the write edge
    task automatic wr_reg(input logic [3:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk);
        #1;
        reg_wr = 1'b0;
    endtask

    // Read in the low phase; call only after a negedge
    task automatic rd_reg(input logic [3:0] a, output logic [15:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    // Snapshot all fields in one low phase and compare with the model
    task automatic compare_all();
        logic [15:0] v;
        rd_reg(4'd1, v); check("R3 seconds", v, {8'h00, to_bcd(m_sec)});
        rd_reg(4'd2, v); check("R3 minutes", v, {8'h00, to_bcd(m_min)});
        rd_reg(4'd3, v); check("R4 hours", v, {8'h00, to_bcd(m_hr)});
        rd_reg(4'd4, v); check("R5 weekday", v, {8'h00, to_bcd(m_wd)});
        rd_reg(4'd5, v); check("R6 day", v, {8'h00, to_bcd(m_md)});
        rd_reg(4'd6, v); check("R7 month", v, {8'h00, to_bcd(m_mo)});
        rd_reg(4'd7, v); check("R7 year+leap", v, {m_leap, 7'd0, to_bcd(m_yr)});
    endtask

    task automatic load_time(input int s, input int mi, input int h, input int wd,
                             input int md, input int mo, input int yr, input bit lp);
        wr_reg(4'd1, {8'h00, to_bcd(s)});
        wr_reg(4'd2, {8'h00, to_bcd(mi)});
        wr_reg(4'd3, {8'h00, to_bcd(h)});
        wr_reg(4'd4, {8'h00, to_bcd(wd)});
        wr_reg(4'd5, {8'h00, to_bcd(md)});
        wr_reg(4'd6, {8'h00, to_bcd(mo)});
        wr_reg(4'd7, {lp, 7'd0, to_bcd(yr)});
        wr_reg(4'd8, 16'h8000);
        m_sec = s; m_min = mi; m_hr = h; m_wd = wd;
        m_md = md; m_mo = mo; m_yr = yr; m_leap = lp;
    endtask

    // Load, run k seconds, compare
    task automatic run_case(input int s, input int mi, input int h, input int wd,
                            input int md, input int mo, input int yr, input bit lp,
                            input int k);
        load_time(s, mi, h, wd, md, mo, yr, lp);
        repeat (k * P) @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < k; i++) model_step();
        compare_all();
    endtask

    initial begin
        #3_000_000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual running expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        void'($urandom(32'd20240407));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        @(negedge clk);
        check("R1 tick low", {15'd0, sec_tick}, 16'd0);
        m_sec = 0; m_min = 0; m_hr = 0; m_wd = 0; m_md = 1; m_mo = 1; m_yr = 0; m_leap = 0;
        compare_all();
        rd_reg(4'd0, v); check("R1 control reset", v, 16'h0001);

        // R2 tick timing after a commit
        load_time(10, 20, 5, 2, 14, 7, 33, 1'b0);
        repeat (P - 2) @(posedge clk);
        @(negedge clk); check("R2 tick before", {15'd0, sec_tick}, 16'd0);
        @(posedge clk);
        @(negedge clk); check("R2 tick high", {15'd0, sec_tick}, 16'd1);
        rd_reg(4'd1, v); check("R2 not yet advanced", v, 16'h0010);
        @(posedge clk);
        @(negedge clk); check("R2 tick single", {15'd0, sec_tick}, 16'd0);
        rd_reg(4'd1, v); check("R2 advanced", v, 16'h0011);

        // R8 shadow writes do not reach live; R9 update without trigger
        load_time(30, 40, 12, 3, 9, 9, 50, 1'b0);
        wr_reg(4'd1, 16'h0045);
        wr_reg(4'd3, 16'h0007);
        @(negedge clk);
        rd_reg(4'd1, v); check("R8 shadow sec hidden", v, 16'h0030);
        rd_reg(4'd3, v); check("R8 shadow hour hidden", v, 16'h0012);
        wr_reg(4'd8, 16'h7FFF);
        @(negedge clk);
        rd_reg(4'd1, v); check("R9 no trigger no load", v, 16'h0030);
        rd_reg(4'd8, v); check("R9 update reads zero", v, 16'h0000);
        wr_reg(4'd8, 16'h8000);
        @(negedge clk);
        rd_reg(4'd1, v); check("R9 commit sec", v, 16'h0045);
        rd_reg(4'd3, v); check("R9 commit hour", v, 16'h0007);
        rd_reg(4'd2, v); check("R9 commit kept min", v, 16'h0040);
        rd_reg(4'd8, v); check("R9 update reads zero after", v, 16'h0000);

        // R8 field masking: weekday stores 3 bits
        wr_reg(4'd4, 16'hFF05);
        wr_reg(4'd8, 16'h8000);
        @(negedge clk);
        rd_reg(4'd4, v); check("R8 weekday masked", v, 16'h0005);

        // R10 control and unmapped addresses
        wr_reg(4'd0, 16'h0000);
        @(negedge clk);
        rd_reg(4'd0, v); check("R10 control cleared", v, 16'h0000);
        wr_reg(4'd0, 16'hFFFF);
        @(negedge clk);
        rd_reg(4'd0, v); check("R10 control set", v, 16'h0001);
        rd_reg(4'd9, v); check("R10 addr 9 zero", v, 16'h0000);
        rd_reg(4'd15, v); check("R10 addr 15 zero", v, 16'h0000);

        // Directed rollovers
        run_case(59, 59, 23, 6, 28, 2, 23, 1'b0, 1); // R6 Feb non-leap, R5 wrap
        run_case(59, 59, 23, 1, 28, 2, 24, 1'b1, 1); // R6 Feb leap to 29
        run_case(59, 59, 23, 2, 29, 2, 24, 1'b1, 1); // R6 Feb 29 to Mar 1
        run_case(59, 59, 23, 3, 30, 4, 40, 1'b0, 1); // R6 30-day month
        run_case(59, 59, 23, 4, 30, 5, 40, 1'b0, 1); // R6 31-day month mid
        run_case(59, 59, 23, 5, 31, 12, 99, 1'b1, 2); // R7 year wrap, leap kept
        run_case(58, 59, 9, 0, 15, 6, 10, 1'b0, 3);  // R3 R4 minute and 09->10

        // Random times biased to field limits
        for (int it = 0; it < 60; it++) begin
            int s, mi, h, wd, md, mo, yr, k, len;
            bit lp;
            lp = 1'($urandom_range(0, 1));
            mo = ($urandom_range(0, 3) == 0) ? 12 : $urandom_range(1, 12);
            len = mlen(mo, lp);
            md = ($urandom_range(0, 2) == 0) ? len : $urandom_range(1, len);
            s  = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
            mi = ($urandom_range(0, 1) == 0) ? 59 : $urandom_range(0, 59);
            h  = ($urandom_range(0, 1) == 0) ? 23 : $urandom_range(0, 23);
            wd = $urandom_range(0, 6);
            yr = ($urandom_range(0, 3) == 0) ? 99 : $urandom_range(0, 99);
            k  = $urandom_range(1, 3);
            run_case(s, mi, h, wd, md, mo, yr, lp, k);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule